// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits inside a byte-wide flash memory model, between the bus front end and the internal write engine. The front end has already resolved the write-enable and chip-enable edges. It presents one write-strobe pulse per bus write cycle, with the latched address and data byte. The decoder checks each write against the unlock-protected command sequences. It recognises byte program, sector erase, chip erase, and entry to and exit from identification mode. When a sequence completes, it issues a one-clock start request that carries an operation code, the target address and, for a program, the data byte.

While the write engine reports busy, the decoder accepts no write at all. It also tracks identification mode. In that mode it returns the manufacturer code or a configurable device code, selected by read address bit 0, on a registered identification data output.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `op_start` is 0, `op_kind` is 00, `id_mode` is 0 and the decoder waits for the first unlock write.
- R2: The byte program sequence is four accepted writes: AAh to 555h, 55h to 2AAh, A0h to 555h, then any address with any data. On the clock edge that samples the fourth write, `op_start` rises with `op_kind` = 01, `op_addr` equal to the full write address and `op_data` equal to the written byte.
- R3: The sector erase sequence is AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 20h at any address. It starts with `op_kind` = 10. `op_addr` is the write address with bits 6..0 forced to 0, so sectors are 128 bytes.
- R4: The chip erase sequence uses the same five-write prefix as R3 and ends with 10h at 555h. It starts with `op_kind` = 11 and `op_addr` = 0. At the final step, any data value other than 20h or 10h@555h starts nothing.
- R5: Only address bits 14..0 are compared in the unlock and command steps. Bits above 14 do not affect recognition.
- R6: A write that does not match the expected step aborts the sequence back to the waiting state. That write does not itself begin a new sequence, so a full sequence must then be written again from its first step.
- R7: AAh@555h, 55h@2AAh, 90h@555h sets `id_mode`. While `id_mode` is 1, `id_data` returns BFh when `rd_sel` is 0 and the `DEV_CODE` parameter when `rd_sel` is 1, one clock after `rd_sel` is sampled. While `id_mode` is 0, `id_data` is 00h.
- R8: `id_mode` is cleared in two ways. One is a single write of F0h at any address. The other is AAh@555h, 55h@2AAh, F0h@555h. A write of F0h at any step other than the program data step clears it.
- R9: A write presented while `busy` is 1 is ignored. It starts nothing, leaves the sequence position unchanged and leaves `id_mode` unchanged, and this includes the exit command.
- R10: `op_start` is high for exactly one clock per completed sequence, and `op_kind` is 00 whenever `op_start` is 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-clock pulse per resolved bus write |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | 8 | Latched write data |
| busy | input | 1 | Write engine is programming or erasing |
| rd_sel | input | 1 | Read address bit 0, selects identification byte |
| op_start | output | 1 | One-clock start request to the write engine |
| op_kind | output | 2 | 01 program, 10 sector erase, 11 chip erase, 00 none |
| op_addr | output | ADDR_W | Target byte or sector base address |
| op_data | output | 8 | Byte to program |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification byte, 00h outside the mode |

## Verification
All 256 values are swept through the second unlock step. Only 55h may let a following program start, which separates exact data matching from partial matching. All 256 values are also swept through the final erase step, at an address whose low bits are 555h and whose upper bits are set. This separates sector erase, chip erase, exit and no-operation, and shows that the upper bits are ignored. The sweep of upper address bits across every unlock write, and the sweeps of sector and program addresses, tell address masking apart from full-width compares. A busy window placed in the middle of a sequence and over the exit command tells "ignored and held" apart from "aborted".

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_SECT = 2'b10,
    OP_CHIP = 2'b11
  } fcd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_UNL1  = 3'd1,
    ST_UNL2  = 3'd2,
    ST_PDATA = 3'd3,
    ST_EUNL3 = 3'd4,
    ST_EUNL4 = 3'd5,
    ST_EFIN  = 3'd6
  } fcd_st_e;

  // decoded properties of the write being presented
  typedef struct packed {
    logic aa_u1;   // AAh at first unlock address
    logic x55_u2;  // 55h at second unlock address
    logic a0_cmd;  // program command at command address
    logic x80_cmd; // erase setup at command address
    logic x90_cmd; // identification entry at command address
    logic f0_any;  // F0h at any address
    logic x20_any; // sector erase code at any address
    logic x10_cmd; // chip erase code at command address
  } fcd_hit_t;

  localparam logic [7:0] CODE_UNLK1 = 8'hAA;
  localparam logic [7:0] CODE_UNLK2 = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ESET  = 8'h80;
  localparam logic [7:0] CODE_IDIN  = 8'h90;
  localparam logic [7:0] CODE_IDOUT = 8'hF0;
  localparam logic [7:0] CODE_SECT  = 8'h20;
  localparam logic [7:0] CODE_CHIP  = 8'h10;

endpackage

// File: rtl/fcd_step_match.sv
module fcd_step_match
  import fcd_pkg::*;
#(
  parameter int CMP_W = 15,
  parameter logic [CMP_W-1:0] ADR_A = 15'h555,
  parameter logic [CMP_W-1:0] ADR_B = 15'h2AA
) (
  input  logic [CMP_W-1:0] low_addr,
  input  logic [7:0]       data,
  output fcd_hit_t         hit
);
  logic at_a;
  logic at_b;

  always_comb begin
    at_a        = (low_addr == ADR_A);
    at_b        = (low_addr == ADR_B);
    hit.aa_u1   = at_a && (data == CODE_UNLK1);
    hit.x55_u2  = at_b && (data == CODE_UNLK2);
    hit.a0_cmd  = at_a && (data == CODE_PROG);
    hit.x80_cmd = at_a && (data == CODE_ESET);
    hit.x90_cmd = at_a && (data == CODE_IDIN);
    hit.f0_any  = (data == CODE_IDOUT);
    hit.x20_any = (data == CODE_SECT);
    hit.x10_cmd = at_a && (data == CODE_CHIP);
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int SECT_LSB = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  fcd_hit_t          hit,
  output logic              start,
  output fcd_op_e           kind,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        tgt_data,
  output logic              id_set,
  output logic              id_clr
);
  localparam int SECT_HI = ADDR_W - SECT_LSB;

  fcd_st_e           st_q, st_n;
  logic              fire;
  fcd_op_e           fire_kind;
  logic [ADDR_W-1:0] fire_addr;
  logic [7:0]        fire_data;

  always_comb begin
    st_n      = st_q;
    fire      = 1'b0;
    fire_kind = OP_NONE;
    fire_addr = '0;
    fire_data = '0;
    id_set    = 1'b0;
    id_clr    = 1'b0;
    if (take) begin
      st_n = ST_IDLE;
      // exit code clears identification mode everywhere except the program data step
      if (st_q != ST_PDATA) id_clr = hit.f0_any;
      unique case (st_q)
        ST_IDLE:  if (hit.aa_u1)  st_n = ST_UNL1;
        ST_UNL1:  if (hit.x55_u2) st_n = ST_UNL2;
        ST_UNL2: begin
          if (hit.a0_cmd)       st_n = ST_PDATA;
          else if (hit.x80_cmd) st_n = ST_EUNL3;
          else if (hit.x90_cmd) id_set = 1'b1;
        end
        ST_PDATA: begin
          fire      = 1'b1;
          fire_kind = OP_PROG;
          fire_addr = addr;
          fire_data = data;
        end
        ST_EUNL3: if (hit.aa_u1)  st_n = ST_EUNL4;
        ST_EUNL4: if (hit.x55_u2) st_n = ST_EFIN;
        ST_EFIN: begin
          if (hit.x20_any) begin
            fire      = 1'b1;
            fire_kind = OP_SECT;
            fire_addr = {addr[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
          end else if (hit.x10_cmd) begin
            fire      = 1'b1;
            fire_kind = OP_CHIP;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      start    <= 1'b0;
      kind     <= OP_NONE;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      st_q     <= st_n;
      start    <= fire;
      kind     <= fire_kind;
      tgt_addr <= fire_addr;
      tgt_data <= fire_data;
    end
  end

  AST_START_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    start |=> !start) else $error("start wider than one clock"); // R10
  AST_KIND_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !start |-> (kind == OP_NONE)) else $error("kind set without start"); // R10
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    start |-> (kind != OP_NONE)) else $error("start without kind"); // R2
  AST_SECTOR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (start && kind == OP_SECT) |-> (tgt_addr[SECT_LSB-1:0] == '0)) else $error("sector misaligned"); // R3
  AST_CHIP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start && kind == OP_CHIP) |-> (tgt_addr == '0)) else $error("chip erase address"); // R4
  AST_START_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(take)) else $error("start without accepted write"); // R9
  localparam int UNUSED_HI = SECT_HI;
endmodule

// File: rtl/fcd_id_ctl.sv
module fcd_id_ctl #(
  parameter logic [7:0] MFR_CODE = 8'hBF,
  parameter logic [7:0] DEV_CODE = 8'h13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       id_set,
  input  logic       id_clr,
  input  logic       busy,
  input  logic       rd_sel,
  output logic       id_mode,
  output logic [7:0] id_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      id_mode <= 1'b0;
      id_data <= 8'h00;
    end else begin
      if (id_set)      id_mode <= 1'b1;
      else if (id_clr) id_mode <= 1'b0;
      id_data <= id_mode ? (rd_sel ? DEV_CODE : MFR_CODE) : 8'h00;
    end
  end

  AST_BUSY_HOLDS_ID: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(id_mode)) else $error("id mode moved while busy"); // R9
  AST_ID_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !id_mode |=> (id_data == 8'h00)) else $error("id data outside mode"); // R7
  AST_ID_ON_CODE: assert property (@(posedge clk) disable iff (rst)
    (id_mode && !rd_sel) |=> (id_data == MFR_CODE)) else $error("manufacturer byte"); // R7
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W   = 19,
  parameter int         CMP_W    = 15,
  parameter int         SECT_LSB = 7,
  parameter logic [7:0] MFR_CODE = 8'hBF,
  parameter logic [7:0] DEV_CODE = 8'h13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              rd_sel,
  output logic              op_start,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              id_mode,
  output logic [7:0]        id_data
);
  localparam logic [CMP_W-1:0] ADR_A = CMP_W'(15'h555);
  localparam logic [CMP_W-1:0] ADR_B = CMP_W'(15'h2AA);

  fcd_hit_t hit;
  fcd_op_e  kind_w;
  logic     take;
  logic     id_set;
  logic     id_clr;

  assign take = wr_stb && !busy;

  fcd_step_match #(.CMP_W(CMP_W), .ADR_A(ADR_A), .ADR_B(ADR_B)) u_match (
    .low_addr (wr_addr[CMP_W-1:0]),
    .data     (wr_data),
    .hit      (hit)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .addr     (wr_addr),
    .data     (wr_data),
    .hit      (hit),
    .start    (op_start),
    .kind     (kind_w),
    .tgt_addr (op_addr),
    .tgt_data (op_data),
    .id_set   (id_set),
    .id_clr   (id_clr)
  );

  assign op_kind = kind_w;

  fcd_id_ctl #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk     (clk),
    .rst     (rst),
    .id_set  (id_set),
    .id_clr  (id_clr),
    .busy    (busy),
    .rd_sel  (rd_sel),
    .id_mode (id_mode),
    .id_data (id_data)
  );

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    op_start |-> !$past(busy)) else $error("start from busy write"); // R9
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int AW = 19;
  localparam logic [7:0] DEV = 8'h13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          busy = 1'b0;
  logic          rd_sel = 1'b0;
  logic          op_start;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic          id_mode;
  logic [7:0]    id_data;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DEV_CODE(DEV)) dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_sel(rd_sel), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode), .id_data(id_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic unlock(input logic [3:0] up);
    wr({up, 15'h555}, 8'hAA);
    wr({up, 15'h2AA}, 8'h55);
  endtask

  task automatic exp_start(input string tag, input logic [1:0] k,
                           input logic [AW-1:0] a, input logic [7:0] d);
    chk({tag, " start"}, 32'(op_start), 32'd1);
    chk({tag, " kind"}, 32'(op_kind), 32'(k));
    chk({tag, " addr"}, 32'(op_addr), 32'(a));
    chk({tag, " data"}, 32'(op_data), 32'(d));
  endtask

  task automatic exp_none(input string tag);
    chk({tag, " start"}, 32'(op_start), 32'd0);
    chk({tag, " kind"}, 32'(op_kind), 32'd0);
  endtask

  task automatic read_id(input logic sel, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_sel = sel;
    @(negedge clk);
    chk(tag, 32'(id_data), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start", 32'(op_start), 0);
    chk("R1 kind", 32'(op_kind), 0);
    chk("R1 id_mode", 32'(id_mode), 0);
    chk("R1 id_data", 32'(id_data), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 program with address/data spread; R10 one clock wide
    for (int i = 0; i < 32; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'(i * 16411 + 7);
      d = 8'(i * 37 + 5);
      unlock(4'h0);
      wr(19'h555, 8'hA0);
      wr(a, d);
      exp_start("R2 program", 2'b01, a, d);
      @(negedge clk);
      exp_none("R10 after start");
    end

    // R6 second-step data sweep: only 55h lets the program through
    for (int d = 0; d < 256; d++) begin
      wr(19'h555, 8'hAA);
      wr(19'h2AA, 8'(d));
      wr(19'h555, 8'hA0);
      wr(19'h1234A, 8'h5A);
      if (d == 8'h55) exp_start("R6 step2 match", 2'b01, 19'h1234A, 8'h5A);
      else            exp_none("R6 step2 mismatch");
    end

    // R3/R4/R5 final erase step sweep at address with upper bits set
    for (int d = 0; d < 256; d++) begin
      unlock(4'h6);
      wr(19'h30555, 8'h80);
      unlock(4'hA);
      wr(19'h30555, 8'(d));
      if (d == 8'h20)      exp_start("R3 sector", 2'b10, 19'h30500, 8'h00);
      else if (d == 8'h10) exp_start("R4 chip", 2'b11, 19'h00000, 8'h00);
      else                 exp_none("R4 other final");
    end

    // R3 sector base alignment sweep
    for (int s = 0; s < 16; s++) begin
      logic [AW-1:0] a;
      a = AW'(s * 19'h1235 + 19'h3F);
      unlock(4'h0); wr(19'h555, 8'h80); unlock(4'h0);
      wr(a, 8'h20);
      exp_start("R3 sector align", 2'b10, {a[AW-1:7], 7'h00}, 8'h00);
    end

    // R5 upper address bits ignored on all unlock writes
    for (int u = 0; u < 16; u++) begin
      unlock(4'(u));
      wr({4'(u), 15'h555}, 8'hA0);
      wr(19'h00777, 8'(u));
      exp_start("R5 upper bits", 2'b01, 19'h00777, 8'(u));
    end

    // R6 abort, then the tail of a sequence does nothing
    wr(19'h555, 8'hAA);
    wr(19'h555, 8'hAA);
    wr(19'h2AA, 8'h55);
    wr(19'h555, 8'hA0);
    wr(19'h00100, 8'h33);
    exp_none("R6 abort restart");

    // R7 identification entry and reads
    unlock(4'h0); wr(19'h555, 8'h90);
    chk("R7 id_mode set", 32'(id_mode), 1);
    read_id(1'b0, 8'hBF, "R7 manufacturer");
    read_id(1'b1, DEV, "R7 device");
    // R8 single-write exit at arbitrary address
    wr(19'h7ABCD, 8'hF0);
    chk("R8 single exit", 32'(id_mode), 0);
    read_id(1'b1, 8'h00, "R7 id_data off");
    // R8 three-write exit
    unlock(4'h0); wr(19'h555, 8'h90);
    unlock(4'h0); wr(19'h555, 8'hF0);
    chk("R8 long exit", 32'(id_mode), 0);

    // R9 exit ignored while busy
    unlock(4'h0); wr(19'h555, 8'h90);
    @(negedge clk); busy = 1'b1;
    wr(19'h00000, 8'hF0);
    chk("R9 busy exit ignored", 32'(id_mode), 1);
    @(negedge clk); busy = 1'b0;
    wr(19'h00000, 8'hF0);
    chk("R8 exit after busy", 32'(id_mode), 0);

    // R9 busy mid-sequence holds the step
    unlock(4'h0);
    @(negedge clk); busy = 1'b1;
    wr(19'h555, 8'hA0);
    exp_none("R9 busy command");
    @(negedge clk); busy = 1'b0;
    wr(19'h555, 8'hA0);
    @(negedge clk); busy = 1'b1;
    wr(19'h04444, 8'h99);
    exp_none("R9 busy data");
    @(negedge clk); busy = 1'b0;
    wr(19'h04444, 8'h99);
    exp_start("R9 resumed program", 2'b01, 19'h04444, 8'h99);

    // R8 F0h as program data programs and does not exit
    unlock(4'h0); wr(19'h555, 8'h90);
    unlock(4'h0); wr(19'h555, 8'hA0);
    wr(19'h00042, 8'hF0);
    exp_start("R8 F0 as data", 2'b01, 19'h00042, 8'hF0);
    chk("R8 id kept", 32'(id_mode), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule